// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a host-side SPI flash controller that software drives one command at a time. Software first loads an eight-entry opcode menu, a two-bit type code for each entry, two prefix opcodes, a 24-bit flash address and up to 64 data bytes through a small word-addressed register port. It then writes the control word with the go bit set. The block runs a single mode-0 SPI transaction on one chip select. For an atomic command it first sends the chosen prefix opcode as a frame of its own. Progress and completion are reported in a status word.

Register word map (`reg_addr`): 0 flash address, 1 status, 2 control, 3 prefix pair, 4 type codes, 5 menu entries 0-3, 6 menu entries 4-7, 7 clock divider, 16 upward data buffer words. Register reads are combinational. A register write takes effect at the clock edge that samples it.

Top module: `spi_seq_master`

## Requirements
- R1: After reset the status and control words read 0, the divider reads 1, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: The control word's menu index n (bits 6:4) selects opcode byte 8n+7:8n of the 64-bit menu (word 5 is bits 31:0, word 6 is bits 63:32) and type code bits 2n+1:2n of word 4. The type codes are 0 = read without address, 1 = write without address, 2 = read with address, 3 = write with address.
- R3: Types 2 and 3 send the low 24 bits of word 0, most significant byte first, right after the opcode. Types 0 and 1 send no address. Bits 31:24 of word 0 read back as 0.
- R4: A write type with the data-phase bit (control bit 14) set sends (bits 13:8)+1 bytes after the header. Byte k comes from bits 8*(k mod 4)+7:8*(k mod 4) of buffer word 16+k/4.
- R5: A read type with the data-phase bit set drives MOSI low for (bits 13:8)+1 bytes. It stores each byte shifted in from MISO into the buffer at the same position a write would have taken it from.
- R6: With the data-phase bit clear, only the opcode and any address are sent, whatever the byte count. The buffer is left unchanged.
- R7: With control bit 2 set, the prefix opcode selected by control bit 3 is sent first as a one-byte frame. Bit 3 = 0 selects prefix bits 7:0 of word 3 and bit 3 = 1 selects bits 15:8. Chip select then goes high for at least two SPI clocks before the command frame, and the in-progress flag stays set across both frames.
- R8: The in-progress flag (status bit 0) is set from the cycle after a go write until the command ends. At the end, done (bit 2) sets. Writing 1 to status bit 2 or bit 3 clears that flag.
- R9: A go write while in progress sets error (bit 3) and done, and does not alter the running command.
- R10: SPI mode 0: SCLK rests low, MOSI changes only on falling edges and MISO is sampled on rising edges. The half period is (divider+1) system clocks.
- R11: Chip select stays low for a whole frame and stays high for at least two SPI clocks after each frame.
- R12: The byte-count field is log2(MAX_BYTES) bits wide. At 64 a count field of 63 moves 64 bytes. At 16 the field keeps only its low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A go write is sampled at one edge. Status bit 0 reads 1 from the next cycle, so the bench polls status once per cycle at the falling clock edge and never samples in the cycle of the write. SPI frames are collected by a behavioural flash model on SCLK and chip-select edges. They are compared with expected byte queues only after in-progress has dropped. The frame count at that moment shows whether in-progress stayed high across an atomic prefix gap. Chip-select high time and the spacing between rising SCLK edges are measured in system clocks at every falling clock edge, and the SCLK-low-while-deselected rule is compared on every clock.

// File: rtl/spi_seq_master.sv
module spi_seq_master #(
  parameter int MAX_BYTES = 64,
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int CNT_W = $clog2(MAX_BYTES);
  localparam int WORDS = MAX_BYTES / 4;
  localparam int WI_W  = $clog2(WORDS);
  localparam logic [4:0] A_ADDR = 5'd0, A_STAT = 5'd1, A_CTRL = 5'd2, A_PRE = 5'd3,
                         A_TYPE = 5'd4, A_MLO = 5'd5, A_MHI = 5'd6, A_DIV = 5'd7;

  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_GAP, PH_CMD, PH_ADR, PH_DAT, PH_TAIL} ph_t;

  logic [23:0] addr_q;
  logic [15:0] pre_q, typ_q;
  logic [63:0] menu_q;
  logic [DIV_W-1:0] div_q, dcnt_q;
  logic busy_q, done_q, err_q, atom_q, psel_q, den_q;
  logic [2:0] idx_q, bitc_q;
  logic [CNT_W-1:0] cnt_q, bcnt_q;
  logic [1:0] gcnt_q;
  logic [7:0] tx_q, rx_q;
  logic sclk_q, cs_n_q;
  ph_t ph_q;
  logic [7:0] mem [MAX_BYTES];

  logic go_wr, start, tick, last_fall, cap, buf_wr;
  logic [1:0] cur_ty;
  logic [7:0] cur_op, first_byte, first_data;
  logic [WI_W-1:0] wi;

  assign go_wr      = reg_we && reg_addr == A_CTRL && reg_wdata[1];
  assign start      = go_wr && !busy_q;
  assign tick       = busy_q && dcnt_q == div_q;
  assign last_fall  = tick && !cs_n_q && sclk_q && bitc_q == 3'd7;
  assign cur_op     = menu_q[{idx_q, 3'b000} +: 8];
  assign cur_ty     = typ_q[{idx_q, 1'b0} +: 2];
  assign first_data = cur_ty[0] ? mem[0] : 8'h00;
  assign first_byte = reg_wdata[2] ? (reg_wdata[3] ? pre_q[15:8] : pre_q[7:0])
                                   : menu_q[{reg_wdata[6:4], 3'b000} +: 8];
  assign cap        = last_fall && ph_q == PH_DAT && !cur_ty[0];
  assign wi         = reg_addr[WI_W-1:0];
  assign buf_wr     = reg_we && reg_addr[4] && ({1'b0, reg_addr[3:0]} < 5'(WORDS));

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_n_q;
  assign spi_mosi = tx_q[7];

  always_ff @(posedge clk) begin
    if (buf_wr)
      for (int k = 0; k < 4; k++) mem[{wi, 2'(k)}] <= reg_wdata[8*k +: 8];
    if (cap) mem[bcnt_q] <= rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; pre_q <= '0; typ_q <= '0; menu_q <= '0; div_q <= DIV_RESET;
      dcnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      atom_q <= 1'b0; psel_q <= 1'b0; den_q <= 1'b0; idx_q <= '0; cnt_q <= '0;
      bitc_q <= '0; bcnt_q <= '0; gcnt_q <= '0; tx_q <= '0; rx_q <= '0;
      sclk_q <= 1'b0; cs_n_q <= 1'b1; ph_q <= PH_IDLE;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_ADDR: addr_q <= reg_wdata[23:0];
          A_PRE:  pre_q <= reg_wdata[15:0];
          A_TYPE: typ_q <= reg_wdata[15:0];
          A_MLO:  menu_q[31:0] <= reg_wdata;
          A_MHI:  menu_q[63:32] <= reg_wdata;
          A_DIV:  div_q <= reg_wdata[DIV_W-1:0];
          A_STAT: begin
            if (reg_wdata[2]) done_q <= 1'b0;
            if (reg_wdata[3]) err_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (go_wr && busy_q) begin
        err_q <= 1'b1;
        done_q <= 1'b1;
      end
      dcnt_q <= (!busy_q || tick) ? '0 : dcnt_q + 1'b1;

      if (start) begin
        busy_q <= 1'b1; cs_n_q <= 1'b0; sclk_q <= 1'b0; bitc_q <= '0; bcnt_q <= '0;
        atom_q <= reg_wdata[2]; psel_q <= reg_wdata[3]; idx_q <= reg_wdata[6:4];
        cnt_q <= reg_wdata[8 +: CNT_W]; den_q <= reg_wdata[14];
        ph_q <= reg_wdata[2] ? PH_PRE : PH_CMD;
        tx_q <= first_byte;
      end else if (tick) begin
        if (!cs_n_q) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q <= {rx_q[6:0], spi_miso};
          end else begin
            sclk_q <= 1'b0;
            bitc_q <= bitc_q + 1'b1;
            tx_q <= {tx_q[6:0], 1'b0};
            if (bitc_q == 3'd7) begin
              bcnt_q <= '0;
              case (ph_q)
                PH_PRE: begin cs_n_q <= 1'b1; ph_q <= PH_GAP; gcnt_q <= '0; end
                PH_CMD, PH_ADR: begin
                  if (ph_q == PH_CMD && cur_ty[1]) begin
                    ph_q <= PH_ADR; tx_q <= addr_q[23:16];
                  end else if (ph_q == PH_ADR && bcnt_q != CNT_W'(2)) begin
                    bcnt_q <= bcnt_q + 1'b1;
                    tx_q <= (bcnt_q == '0) ? addr_q[15:8] : addr_q[7:0];
                  end else if (den_q) begin
                    ph_q <= PH_DAT; tx_q <= first_data;
                  end else begin
                    ph_q <= PH_TAIL; cs_n_q <= 1'b1; gcnt_q <= '0;
                  end
                end
                PH_DAT: begin
                  if (bcnt_q != cnt_q) begin
                    bcnt_q <= bcnt_q + 1'b1;
                    tx_q <= cur_ty[0] ? mem[bcnt_q + 1'b1] : 8'h00;
                  end else begin
                    ph_q <= PH_TAIL; cs_n_q <= 1'b1; gcnt_q <= '0;
                  end
                end
                default: ;
              endcase
            end
          end
        end else begin
          gcnt_q <= gcnt_q + 1'b1;
          if (gcnt_q == 2'd3) begin
            if (ph_q == PH_GAP) begin
              ph_q <= PH_CMD; cs_n_q <= 1'b0; tx_q <= cur_op;
            end else begin
              ph_q <= PH_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[4]) begin
      if ({1'b0, reg_addr[3:0]} < 5'(WORDS))
        reg_rdata = {mem[{wi, 2'd3}], mem[{wi, 2'd2}], mem[{wi, 2'd1}], mem[{wi, 2'd0}]};
    end else begin
      case (reg_addr)
        A_ADDR: reg_rdata[23:0] = addr_q;
        A_STAT: begin reg_rdata[0] = busy_q; reg_rdata[2] = done_q; reg_rdata[3] = err_q; end
        A_CTRL: begin
          reg_rdata[1] = busy_q; reg_rdata[2] = atom_q; reg_rdata[3] = psel_q;
          reg_rdata[6:4] = idx_q; reg_rdata[8 +: CNT_W] = cnt_q; reg_rdata[14] = den_q;
        end
        A_PRE:  reg_rdata[15:0] = pre_q;
        A_TYPE: reg_rdata[15:0] = typ_q;
        A_MLO:  reg_rdata = menu_q[31:0];
        A_MHI:  reg_rdata = menu_q[63:32];
        A_DIV:  reg_rdata[DIV_W-1:0] = div_q;
        default: ;
      endcase
    end
  end

  assert_sclk_rests_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_mosi_steady_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  assert_idle_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> spi_cs_n);
  assert_busy_from_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go_wr));
  assert_go_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && busy_q) |=> (err_q && done_q));
endmodule

// File: tb/spi_seq_master_tb_top.sv
`timescale 1ns/1ps
module spi_seq_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic reg_we = 1'b0; logic [4:0] reg_addr = '0; logic [31:0] reg_wdata = '0; logic [31:0] reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic b_we = 1'b0; logic [4:0] b_addr = '0; logic [31:0] b_wdata = '0; logic [31:0] b_rdata;
  logic b_sclk, b_cs_n, b_mosi;

  spi_seq_master dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));
  spi_seq_master #(.MAX_BYTES(16)) dut16_i (.clk(clk), .rst_n(rst_n), .reg_we(b_we),
    .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(b_rdata), .spi_sclk(b_sclk),
    .spi_cs_n(b_cs_n), .spi_mosi(b_mosi), .spi_miso(1'b0));

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 90) % 256);
  endfunction
  function automatic logic miso_bit(int bi);
    logic [7:0] p;
    p = pat(bi / 8);
    return p[7 - (bi % 8)];
  endfunction
  function automatic logic [31:0] ctl(int idx, int cm1, bit den, bit atom, bit psel);
    return 32'((int'(den) << 14) | (cm1 << 8) | (idx << 4) | (int'(psel) << 3) | (int'(atom) << 2) | 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model: frames of bytes seen on MOSI, MISO from a position pattern
  int sl_bi = 0, sl_bits = 0, cur_len = 0;
  bit sl_in = 0;
  logic [7:0] sl_sh = '0;
  logic [7:0] got_b[$], exp_b[$];
  int got_len[$], exp_len[$];
  assign spi_miso = miso_bit(sl_bi);
  always @(negedge spi_cs_n) if (rst_n) begin sl_in = 1; sl_bi = 0; sl_bits = 0; cur_len = 0; end
  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) sl_bi++;
  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    sl_sh = {sl_sh[6:0], spi_mosi};
    sl_bits++;
    if (sl_bits == 8) begin got_b.push_back(sl_sh); cur_len++; sl_bits = 0; end
  end
  always @(posedge spi_cs_n) if (sl_in) begin got_len.push_back(cur_len); sl_in = 0; end

  int b_rises = 0;
  always @(posedge b_sclk) if (b_cs_n === 1'b0) b_rises++;

  // per-clock line monitor
  int hi_run = 0, min_gap = 1000000, since_rise = 0, sp_min = 1000000, sp_max = 0;
  bit seen_low = 0, have_rise = 0;
  logic prev_sclk = 1'b0;
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R10", {31'b0, spi_cs_n && spi_sclk}, 32'd0, "sclk high while deselected");
    if (spi_cs_n) hi_run++;
    else begin
      if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      seen_low = 1; hi_run = 0;
    end
    if (!spi_cs_n) begin
      since_rise++;
      if (spi_sclk && !prev_sclk) begin
        if (have_rise) begin
          if (since_rise < sp_min) sp_min = since_rise;
          if (since_rise > sp_max) sp_max = since_rise;
        end
        have_rise = 1; since_rise = 0;
      end
    end else have_rise = 0;
    prev_sclk = spi_sclk;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1; fails++;
      $display("FAIL R8 watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic wr16(logic [4:0] a, logic [31:0] d);
    @(negedge clk); b_we = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk); b_we = 1'b0;
  endtask
  task automatic rd16(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); b_addr = a; #1; d = b_rdata;
  endtask

  int frames_at_drop;
  task automatic wait_idle(string req);
    logic [31:0] s;
    int n = 0;
    do begin rd(5'd1, s); n++; end while (s[0] && n < 20000);
    frames_at_drop = got_len.size();
    if (s[0]) chk(req, 32'd1, 32'd0, "command never finished");
  endtask
  task automatic clear_frames();
    got_b.delete(); got_len.delete(); exp_b.delete(); exp_len.delete();
  endtask
  task automatic check_frames(string req);
    chk(req, got_len.size(), exp_len.size(), "frame count");
    for (int i = 0; i < exp_len.size() && i < got_len.size(); i++)
      chk(req, got_len[i], exp_len[i], $sformatf("frame %0d length", i));
    for (int i = 0; i < exp_b.size() && i < got_b.size(); i++)
      chk(req, got_b[i], exp_b[i], $sformatf("byte %0d", i));
  endtask
  task automatic push_hdr(logic [7:0] op, bit adr);
    exp_b.push_back(op);
    if (adr) begin exp_b.push_back(8'h12); exp_b.push_back(8'h34); exp_b.push_back(8'h56); end
  endtask

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'd1, v); chk("R1", v, 32'h0, "status after reset");
    rd(5'd2, v); chk("R1", v, 32'h0, "control after reset");
    rd(5'd7, v); chk("R1", v, 32'h1, "divider after reset");
    chk("R1", {31'b0, spi_cs_n}, 32'd1, "cs_n after reset");
    chk("R1", {31'b0, spi_sclk}, 32'd0, "sclk after reset");

    wr(5'd3, 32'h5006);
    wr(5'd4, 32'hD84B);
    wr(5'd5, 32'h01050302);
    wr(5'd6, 32'hD8C7AB9F);
    wr(5'd0, 32'hAB123456);
    rd(5'd0, v); chk("R3", v, 32'h123456, "address keeps 24 bits");
    wr(5'd16, 32'h44332211);
    wr(5'd17, 32'h88776655);

    // R2 R3 R4 R7 R8: atomic write with address, prefix 0
    clear_frames();
    wr(5'd2, ctl(0, 5, 1, 1, 0));
    wait_idle("R7");
    chk("R7", frames_at_drop, 2, "frames seen when busy dropped");
    exp_len = '{1, 10};
    exp_b.push_back(8'h06); push_hdr(8'h02, 1);
    for (int k = 1; k <= 6; k++) exp_b.push_back(8'(k * 8'h11));
    check_frames("R4");
    rd(5'd1, v); chk("R8", v, 32'h4, "status after completion");
    wr(5'd1, 32'h4);
    rd(5'd1, v); chk("R8", v, 32'h0, "done cleared by write one");

    // R7 prefix 1 with write without address
    clear_frames();
    wr(5'd2, ctl(3, 1, 1, 1, 1));
    wait_idle("R7");
    exp_len = '{1, 3};
    exp_b = '{8'h50, 8'h01, 8'h11, 8'h22};
    check_frames("R7");
    chk("R7", frames_at_drop, 2, "prefix 1 frames when busy dropped");

    // R5 read with address, 5 bytes
    clear_frames();
    wr(5'd2, ctl(1, 4, 1, 0, 0));
    wait_idle("R5");
    exp_len = '{9};
    push_hdr(8'h03, 1);
    repeat (5) exp_b.push_back(8'h00);
    check_frames("R5");
    rd(5'd16, v); chk("R5", v, {pat(7), pat(6), pat(5), pat(4)}, "read buffer word 0");
    rd(5'd17, v); chk("R5", v[7:0], {24'h0, pat(8)}, "read buffer byte 4");

    // R6 data phase disabled: header only, buffer untouched
    clear_frames();
    wr(5'd2, ctl(1, 7, 0, 0, 0));
    wait_idle("R6");
    exp_len = '{4}; push_hdr(8'h03, 1);
    check_frames("R6");
    rd(5'd16, v); chk("R6", v, {pat(7), pat(6), pat(5), pat(4)}, "buffer unchanged");
    clear_frames();
    wr(5'd2, ctl(2, 5, 0, 0, 0));
    wait_idle("R6");
    exp_len = '{1}; exp_b = '{8'h05};
    check_frames("R3");

    // R9 go while busy
    wr(5'd1, 32'hC);
    clear_frames();
    wr(5'd2, ctl(4, 15, 1, 0, 0));
    repeat (30) @(negedge clk);
    wr(5'd2, ctl(2, 0, 0, 0, 0));
    rd(5'd1, v); chk("R9", v, 32'hD, "status after colliding go");
    wait_idle("R9");
    exp_len = '{17}; exp_b.push_back(8'h9F);
    repeat (16) exp_b.push_back(8'h00);
    check_frames("R9");
    rd(5'd1, v); chk("R9", v, 32'hC, "error and done kept after end");
    wr(5'd1, 32'hC);
    rd(5'd1, v); chk("R8", v, 32'h0, "error and done cleared");

    // R12 full 64-byte read
    clear_frames();
    wr(5'd2, ctl(4, 63, 1, 0, 0));
    wait_idle("R12");
    chk("R12", got_len.size() > 0 ? got_len[0] : 0, 65, "64-byte frame length");
    rd(5'd31, v); chk("R12", v, {pat(64), pat(63), pat(62), pat(61)}, "last buffer word");
    rd(5'd16, v); chk("R12", v, {pat(4), pat(3), pat(2), pat(1)}, "first buffer word");

    // R11 chip-select high time with divider 1
    chk("R11", 32'(min_gap >= 8), 32'd1, $sformatf("min cs high %0d", min_gap));

    // R10 divider 3, high menu half with read with address
    wr(5'd7, 32'h3);
    rd(5'd7, v); chk("R10", v, 32'h3, "divider readback");
    sp_min = 1000000; sp_max = 0;
    clear_frames();
    wr(5'd2, ctl(5, 1, 1, 0, 0));
    wait_idle("R10");
    exp_len = '{6}; push_hdr(8'hAB, 1); exp_b.push_back(8'h00); exp_b.push_back(8'h00);
    check_frames("R2");
    chk("R10", sp_min, 8, "min sclk period");
    chk("R10", sp_max, 8, "max sclk period");

    // R12 16-byte build masks count to 4 bits
    wr16(5'd5, 32'h01);
    wr16(5'd4, 32'h1);
    wr16(5'd16, 32'hA5A5A5A5);
    wr16(5'd2, ctl(0, 8'h13, 1, 0, 0));
    rd16(5'd2, v); chk("R12", v[13:8], 32'h3, "masked count field");
    begin
      int n = 0;
      do begin rd16(5'd1, v); n++; end while (v[0] && n < 20000);
    end
    chk("R12", b_rises, 40, "16-byte build sclk edges");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule